// File: doc/BRIEF.md
# I/O Permission Bitmap Checker

This block decides whether an I/O-sensitive instruction may run. It receives one request at a time: the instruction class, the 16-bit port address, the access width, the current privilege level and the I/O privilege field of the flags register. When the current level is numerically at or below the I/O privilege field, every request is allowed at once. Otherwise the two interrupt-flag instructions fault, and port instructions consult a per-port permission bitmap kept in the task state segment.

The bitmap starts at a byte offset given with the request. It may be shorter than full length: its end is implied by the segment limit, and any port whose bit lies past that limit counts as denied. The checker reads at most two bitmap bytes through a read port with a valid/ready request and a separate response strobe. It then emits exactly one single-cycle allow or fault pulse.

Top module: `iop_gate`

## Requirements
- R1: When cpl <= iopl numerically, every operation code gives an allow pulse and no bitmap read is issued.
- R2: Operation codes with bit 2 set (4 = clear interrupt flag, 5 = set interrupt flag; 6 and 7 are handled the same way) give a fault pulse without any read when cpl > iopl.
- R3: Operation codes 0 to 3 (IN, OUT, INS, OUTS) with cpl > iopl are allowed only if bit (p mod 8) of the byte at offset map_base + p/8 is 1 for the port p. A 0 bit denies.
- R4: req_size 0 covers one port, 1 covers two ports and 2 or 3 covers four ports, starting at req_port and counting upward without wraparound. Every covered bit must be 1 for an allow.
- R5: When the covered ports span two bitmap bytes, the lower offset is read first and the higher offset second. A single-byte span issues exactly one read.
- R6: When the offset of the last needed byte exceeds tss_limit (the limit is the last valid offset, inclusive), the request faults and no read is issued.
- R7: Each accepted request yields exactly one pulse, allow or fault, one cycle wide and never both. req_ready is high only while no request is in progress.
- R8: A read request holds rd_valid and rd_addr stable until it is accepted with rd_ready.
- R9: When the first fetched byte already denies a covered port, the second byte is not read.
- R10: During and right after reset, req_ready is high and allow, fault and rd_valid are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when req_ready is high |
| req_ready | output | 1 | Checker idle and able to take a request |
| req_op | input | 3 | Operation code: 0 IN, 1 OUT, 2 INS, 3 OUTS, 4 clear IF, 5 set IF |
| req_port | input | PORT_W | First I/O port address |
| req_size | input | 2 | Access width code: 0 byte, 1 two bytes, 2/3 four bytes |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level field |
| map_base | input | BASE_W | Segment offset of bitmap byte 0 |
| tss_limit | input | OFS_W | Last valid segment offset |
| rd_valid | output | 1 | Bitmap byte read request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | OFS_W | Segment offset of requested byte |
| rsp_valid | input | 1 | Read data present |
| rsp_data | input | 8 | Read data byte |
| allow | output | 1 | One-cycle grant pulse |
| fault | output | 1 | One-cycle general-protection pulse |

## Verification
The range test and the two-byte fetch coincide when an access straddles a byte boundary whose upper byte lies exactly one past the limit. The bench sweeps the limit across a run of ports and all widths, so the straddling request at the edge must fault with no read, while its neighbour one byte lower must read twice. The early-deny shortcut also meets the second fetch. The bench recomputes the read count from the bitmap contents and compares it against the reads the memory model counted.

// File: rtl/iop_pkg.sv
package iop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_WAIT,
    ST_DONE
  } iop_state_e;

  // number of consecutive ports covered by a width code
  function automatic logic [3:0] port_count(input logic [1:0] sz);
    case (sz)
      2'd0:    port_count = 4'd1;
      2'd1:    port_count = 4'd2;
      default: port_count = 4'd4;
    endcase
  endfunction

  // bits of bitmap byte idx that fall inside the port span [lo, hi]
  function automatic logic [7:0] bit_mask(input int unsigned lo,
                                          input int unsigned hi,
                                          input int unsigned idx);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) begin
      m[i] = ((idx * 8 + i) >= lo) && ((idx * 8 + i) <= hi);
    end
    return m;
  endfunction

endpackage

// File: rtl/iop_priv.sv
module iop_priv (
  input  logic [2:0] op,
  input  logic [1:0] cpl,
  input  logic [1:0] iopl,
  output logic       priv_ok,
  output logic       flag_op
);
  assign priv_ok = (cpl <= iopl);
  assign flag_op = op[2];
endmodule

// File: rtl/iop_span.sv
module iop_span #(
  parameter int PORT_W = 16,
  parameter int BASE_W = 16,
  parameter int OFS_W  = 17
) (
  input  logic [PORT_W-1:0] port,
  input  logic [1:0]        size,
  input  logic [BASE_W-1:0] base,
  output logic [PORT_W:0]   bit_lo,
  output logic [PORT_W:0]   bit_hi,
  output logic [OFS_W-1:0]  ofs_lo,
  output logic [OFS_W-1:0]  ofs_hi
);
  import iop_pkg::*;
  localparam int IDX_W = PORT_W - 2;

  logic [IDX_W-1:0] idx_lo;
  logic [IDX_W-1:0] idx_hi;

  assign bit_lo = {1'b0, port};
  assign bit_hi = bit_lo + (PORT_W+1)'(port_count(size) - 4'd1);
  assign idx_lo = bit_lo[PORT_W:3];
  assign idx_hi = bit_hi[PORT_W:3];
  assign ofs_lo = OFS_W'(base) + OFS_W'(idx_lo);
  assign ofs_hi = OFS_W'(base) + OFS_W'(idx_hi);
endmodule

// File: rtl/iop_grant.sv
module iop_grant #(
  parameter int PORT_W = 16
) (
  input  logic [7:0]        data,
  input  logic [PORT_W-2:0] idx,
  input  logic [PORT_W:0]   bit_lo,
  input  logic [PORT_W:0]   bit_hi,
  output logic              ok
);
  import iop_pkg::*;
  logic [7:0] need;
  assign need = bit_mask(32'(bit_lo), 32'(bit_hi), 32'(idx));
  assign ok   = ((data & need) == need);
endmodule

// File: rtl/iop_gate.sv
module iop_gate #(
  parameter int PORT_W = 16,
  parameter int BASE_W = 16,
  parameter int OFS_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [PORT_W-1:0] req_port,
  input  logic [1:0]        req_size,
  input  logic [1:0]        cpl,
  input  logic [1:0]        iopl,
  input  logic [BASE_W-1:0] map_base,
  input  logic [OFS_W-1:0]  tss_limit,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [OFS_W-1:0]  rd_addr,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data,
  output logic              allow,
  output logic              fault
);
  import iop_pkg::*;
  localparam int IDX_W = PORT_W - 2;

  iop_state_e        state;
  logic [2:0]        op_q;
  logic [PORT_W-1:0] port_q;
  logic [1:0]        size_q;
  logic [1:0]        cpl_q;
  logic [1:0]        iopl_q;
  logic [BASE_W-1:0] base_q;
  logic [OFS_W-1:0]  lim_q;
  logic              second_q;
  logic              verdict_q;

  // named internal events
  logic              priv_ok;
  logic              flag_op;
  logic [PORT_W:0]   bit_lo;
  logic [PORT_W:0]   bit_hi;
  logic [OFS_W-1:0]  ofs_lo;
  logic [OFS_W-1:0]  ofs_hi;
  logic              in_range;
  logic              two_bytes;
  logic [IDX_W-1:0]  cur_idx;
  logic              byte_ok;
  logic              take_req;
  logic              rd_fire;
  logic              more_bytes;

  iop_priv u_priv (
    .op      (op_q),
    .cpl     (cpl_q),
    .iopl    (iopl_q),
    .priv_ok (priv_ok),
    .flag_op (flag_op)
  );

  iop_span #(.PORT_W(PORT_W), .BASE_W(BASE_W), .OFS_W(OFS_W)) u_span (
    .port   (port_q),
    .size   (size_q),
    .base   (base_q),
    .bit_lo (bit_lo),
    .bit_hi (bit_hi),
    .ofs_lo (ofs_lo),
    .ofs_hi (ofs_hi)
  );

  assign cur_idx = second_q ? bit_hi[PORT_W:3] : bit_lo[PORT_W:3];

  iop_grant #(.PORT_W(PORT_W)) u_grant (
    .data   (rsp_data),
    .idx    (cur_idx),
    .bit_lo (bit_lo),
    .bit_hi (bit_hi),
    .ok     (byte_ok)
  );

  assign in_range   = (ofs_hi <= lim_q);
  assign two_bytes  = (ofs_hi != ofs_lo);
  assign more_bytes = !second_q && two_bytes;
  assign req_ready  = (state == ST_IDLE);
  assign take_req   = req_valid && req_ready;
  assign rd_valid   = (state == ST_FETCH);
  assign rd_addr    = second_q ? ofs_hi : ofs_lo;
  assign rd_fire    = rd_valid && rd_ready;
  assign allow      = (state == ST_DONE) && verdict_q;
  assign fault      = (state == ST_DONE) && !verdict_q;

  always_ff @(posedge clk) begin
    if (take_req) begin
      op_q   <= req_op;
      port_q <= req_port;
      size_q <= req_size;
      cpl_q  <= cpl;
      iopl_q <= iopl;
      base_q <= map_base;
      lim_q  <= tss_limit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      second_q  <= 1'b0;
      verdict_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (take_req) state <= ST_CHECK;
        end
        ST_CHECK: begin
          second_q <= 1'b0;
          if (priv_ok) begin
            verdict_q <= 1'b1;
            state     <= ST_DONE;
          end else if (flag_op || !in_range) begin
            verdict_q <= 1'b0;
            state     <= ST_DONE;
          end else begin
            state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (rd_fire) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (!byte_ok) begin
              verdict_q <= 1'b0;
              state     <= ST_DONE;
            end else if (more_bytes) begin
              second_q <= 1'b1;
              state    <= ST_FETCH;
            end else begin
              verdict_q <= 1'b1;
              state     <= ST_DONE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

module iop_gate_chk #(
  parameter int OFS_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             allow,
  input logic             fault,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [OFS_W-1:0] rd_addr,
  input logic [OFS_W-1:0] lim_q,
  input logic             flag_op,
  input logic             priv_ok
);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(allow && fault));
  a_r7_allow_single: assert property (@(posedge clk) disable iff (!rst_n)
    allow |=> !allow);
  a_r7_fault_single: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);
  a_r7_busy_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (allow || fault) |-> !req_ready);
  a_r8_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  a_r6_read_in_limit: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_addr <= lim_q));
  a_r2_no_flag_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !flag_op);
  a_r1_no_priv_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !priv_ok);
endmodule

bind iop_gate iop_gate_chk #(.OFS_W(OFS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .allow     (allow),
  .fault     (fault),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_addr   (rd_addr),
  .lim_q     (lim_q),
  .flag_op   (flag_op),
  .priv_ok   (priv_ok)
);

// File: tb/iop_gate_bench.sv
module iop_gate_bench;
  localparam int PORT_W = 16;
  localparam int BASE_W = 16;
  localparam int OFS_W  = 17;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [2:0]        req_op;
  logic [PORT_W-1:0] req_port;
  logic [1:0]        req_size;
  logic [1:0]        cpl;
  logic [1:0]        iopl;
  logic [BASE_W-1:0] map_base;
  logic [OFS_W-1:0]  tss_limit;
  logic              rd_valid;
  logic              rd_ready;
  logic [OFS_W-1:0]  rd_addr;
  logic              rsp_valid;
  logic [7:0]        rsp_data;
  logic              allow;
  logic              fault;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int reads  = 0;
  int first_addr = -1;
  int second_addr = -1;
  int stall_ctr = 0;
  logic pend = 1'b0;
  int   pend_addr = 0;
  int   pend_cnt = 0;

  always #2.5 clk = ~clk;

  iop_gate #(.PORT_W(PORT_W), .BASE_W(BASE_W), .OFS_W(OFS_W)) u_iop_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_port(req_port), .req_size(req_size), .cpl(cpl),
    .iopl(iopl), .map_base(map_base), .tss_limit(tss_limit),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .allow(allow), .fault(fault)
  );

  function automatic logic [7:0] memf(input int a);
    if (a % 3 == 0) return 8'hFF;
    return 8'((a * 73) ^ (a >> 2));
  endfunction

  // memory model, acting between edges
  always @(negedge clk) begin
    cycles++;
    rsp_valid <= 1'b0;
    rd_ready  <= 1'b0;
    stall_ctr++;
    if (pend) begin
      if (pend_cnt == 0) begin
        rsp_valid <= 1'b1;
        rsp_data  <= memf(pend_addr);
        pend      <= 1'b0;
      end else begin
        pend_cnt--;
      end
    end else if (rst_n && rd_valid && (stall_ctr % 3 != 0)) begin
      rd_ready  <= 1'b1;
      pend      <= 1'b1;
      pend_addr = int'(rd_addr);
      pend_cnt  = stall_ctr % 3 - 1;
      if (reads == 0) first_addr = int'(rd_addr);
      else second_addr = int'(rd_addr);
      reads++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (op=%0d port=%h size=%0d cpl=%0d iopl=%0d lim=%h)",
               tag, act, exp, req_op, req_port, req_size, cpl, iopl, tss_limit);
    end
  endtask

  task automatic run_req(input int op, input int port, input int sz,
                         input int c, input int io, input int base, input int lim);
    int n, lo, hi, b0, b1, o0, o1, exp_reads, got_allow, got;
    bit exp_allow, first_ok;
    string tag;
    n  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    lo = port; hi = port + n - 1;
    b0 = lo >> 3; b1 = hi >> 3;
    o0 = base + b0; o1 = base + b1;
    exp_reads = 0;
    if (c <= io) begin
      exp_allow = 1; tag = "R1";
    end else if (op >= 4) begin
      exp_allow = 0; tag = "R2";
    end else if (o1 > lim) begin
      exp_allow = 0; tag = "R6";
    end else begin
      exp_allow = 1; first_ok = 1;
      for (int k = lo; k <= hi; k++) begin
        if (memf(base + (k >> 3))[k & 7] == 1'b0) begin
          exp_allow = 0;
          if ((k >> 3) == b0) first_ok = 0;
        end
      end
      exp_reads = (!first_ok) ? 1 : ((b1 != b0) ? 2 : 1);
      tag = (b1 != b0) ? "R5" : (n > 1) ? "R4" : "R3";
    end
    @(negedge clk);
    reads = 0; first_addr = -1; second_addr = -1;
    req_valid = 1'b1; req_op = 3'(op); req_port = 16'(port); req_size = 2'(sz);
    cpl = 2'(c); iopl = 2'(io); map_base = 16'(base); tss_limit = 17'(lim);
    @(negedge clk);
    req_valid = 1'b0;
    got = 0; got_allow = 0;
    for (int t = 0; t < 60; t++) begin
      if (allow || fault) begin
        got = 1; got_allow = allow ? 1 : 0;
        check(!(allow && fault), "R7", 1, 0);
        check(!req_ready, "R7", int'(req_ready), 0);
        @(negedge clk);
        check(!allow && !fault, "R7", int'(allow) + int'(fault), 0);
        break;
      end
      @(negedge clk);
    end
    if (!got) begin
      check(0, "R7 watchdog", 0, 1);
    end else begin
      check(got_allow == int'(exp_allow), tag, got_allow, int'(exp_allow));
      check(reads == exp_reads, (tag == "R1" || tag == "R2" || tag == "R6") ? tag : "R9",
            reads, exp_reads);
      if (exp_reads >= 1) check(first_addr == o0, "R5", first_addr, o0);
      if (exp_reads == 2) check(second_addr == o1, "R5", second_addr, o1);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_port = '0; req_size = '0;
    cpl = '0; iopl = '0; map_base = '0; tss_limit = '0;
    repeat (3) @(negedge clk);
    check(req_ready && !allow && !fault && !rd_valid, "R10",
          int'({req_ready, allow, fault, rd_valid}), 8);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !allow && !fault && !rd_valid, "R10",
          int'({req_ready, allow, fault, rd_valid}), 8);

    // privilege and class sweep
    for (int c = 0; c < 4; c++)
      for (int io = 0; io < 4; io++)
        for (int op = 0; op < 8; op++)
          run_req(op, 16'h0040 + op * 9, op % 3, c, io, 16'h0068, 17'h2067);

    // bitmap contents sweep, all widths
    for (int p = 0; p < 256; p++)
      for (int sz = 0; sz < 3; sz++)
        run_req(p % 4, p, sz, 3, 0, 16'h0068, 17'h2067);

    // truncated map: limit moved across a run of ports
    for (int l = 0; l < 4; l++)
      for (int p = 128; p < 176; p += 3)
        for (int sz = 0; sz < 3; sz++)
          run_req(1, p, sz, 2, 1, 16'h0068, 16'h0068 + 17 + l);

    // top of the port space
    for (int p = 16'hFFF8; p <= 16'hFFFF; p++)
      for (int sz = 0; sz < 3; sz++)
        run_req(0, p, sz, 3, 1, 16'h0100, 17'h1FFFF);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule